// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is a synchronous master for a multiplexed serial analog-to-digital converter. A user presents a command: a mode/address word, the word length to program and a read-only flag. The controller then runs one complete I/O sequence on the converter's serial pins. It drops the active-low select, clocks the command out MSB first on the serial data output and clocks the previous conversion result in on the serial data input. When the sequence ends it returns the captured word with a one-cycle done strobe.

The converter reports its own state on two lines. An idle line is low while a conversion, calibration, auto-zero or sleep cycle runs. A shift-done line rises once every result bit has left the device. The controller watches both. It never drops select while the converter is busy, because doing so would abort the conversion. It keeps track of the word length that is in force inside the converter, since a new length takes effect only after the sequence that programs it. It drives the converter's sleep pin and holds off all traffic for a programmable wake-up time after the converter is woken. Each wait on the status lines is bounded by a timeout. When a timeout expires the sequence goes ahead, and its result is marked invalid.

Top module: `sadc_host`

## Requirements
- R1: During and right after reset: `adc_sel_n`=1, `adc_sck`=0, `adc_sleep`=0, `adc_read_only`=0, `rsp_valid`=0, `err_timeout`=0, `pwr_ready`=0 and `cmd_ready`=0.
- R2: `adc_sleep` follows `pwr_down` while the controller is idle. While it is high, `pwr_ready` and `cmd_ready` stay low and no sequence starts, even when `cmd_valid` is held. `pwr_ready` rises PWRUP_CYCLES+1 clocks after reset is released or after `adc_sleep` falls.
- R3: `adc_sel_n` falls only while `adc_sck` is low. `adc_mosi` changes only when `adc_sck` falls or while it is low, so it is stable across every rising edge.
- R4: Each sequence has exactly as many `adc_sck` rising edges as the active length. The active length is DEF_LEN (13) after reset. A programming command (`cmd_read_only`=0) carrying `cmd_len`=L makes L the active length from the next sequence on; the programming sequence itself still uses the old length. A read-only command leaves the active length unchanged. `cmd_len` must lie in 1..MAX_W.
- R5: In a programming sequence, the bit on `adc_mosi` at rising edge k (k=0 first) is `cmd_word[MAX_W-1-k]` and `adc_read_only` is 0. In a read-only sequence `adc_mosi` is 0 and `adc_read_only` is 1. In both cases `adc_read_only` is constant while select is low.
- R6: `adc_miso` is sampled at each `adc_sck` rising edge. The result is right-aligned in `rsp_data`, with the first bit received as the most significant and all bits above the active length at zero. The first bit is the one the converter presents when select falls.
- R7: After a programming sequence, select does not fall again until `adc_idle` has been seen low and then high again. Any sequence starts only with `adc_idle` high, unless its wait timed out.
- R8: After the last `adc_sck` falling edge the controller raises select and pulses `rsp_valid` only once `adc_shift_done` is high.
- R9: If `adc_idle` does not satisfy R7 within TIMEOUT_CYCLES clocks, `err_timeout` pulses for one cycle, the sequence starts anyway and its response has `rsp_invalid`=1.
- R10: If `adc_shift_done` does not rise within TIMEOUT_CYCLES clocks after the last bit, `err_timeout` pulses for one cycle, select rises and the response has `rsp_invalid`=1.
- R11: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the acceptance until the response. `rsp_valid` is high for exactly one clock per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, powered and able to accept |
| cmd_word | input | MAX_W | Mode/address word, sent MSB first |
| cmd_len | input | LEN_W | Word length to program (1..MAX_W) |
| cmd_read_only | input | 1 | 1: read the stored result only |
| pwr_down | input | 1 | Request to put the converter to sleep |
| pwr_ready | output | 1 | Converter awake and wake-up time elapsed |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | MAX_W | Captured result, right-aligned |
| rsp_invalid | output | 1 | Response follows a timeout and may be corrupt |
| err_timeout | output | 1 | One-cycle pulse when a status wait expires |
| adc_sel_n | output | 1 | Converter select, active low |
| adc_sck | output | 1 | Serial clock |
| adc_mosi | output | 1 | Serial data to the converter |
| adc_read_only | output | 1 | Read-only control line to the converter |
| adc_sleep | output | 1 | Converter sleep control |
| adc_miso | input | 1 | Serial data from the converter |
| adc_idle | input | 1 | Converter idle (low while busy) |
| adc_shift_done | input | 1 | High once all result bits are out |

## Verification
The hardest situation to reach is a start that is forced into a converter that still looks busy. This needs a programming sequence whose busy pulse never ends, followed by a second command that has to expire its wait. The bench device model has a hold mode that pins the idle line low after the programming sequence and releases it only once the forced read has completed. The same model can withhold shift-done, which drives the second timeout path. It also tracks the length the converter holds, so every test compares the rising-edge count against the length set one command earlier.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAITIDLE,
    S_SETUP,
    S_LOW,
    S_HIGH,
    S_WAITSHIFT,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= 1'b0;
        else     stage <= d[b];
      end
      assign q[b] = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  end
endmodule

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)                cnt <= '0;
    else if (cnt == CW'(DIV - 1))  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int MAX_W          = 16,
  parameter int DEF_LEN        = 13,
  parameter int DIV            = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int PWRUP_CYCLES   = 50000,
  parameter int TIMEOUT_CYCLES = 100000,
  localparam int LEN_W         = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [MAX_W-1:0] cmd_word,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_read_only,
  input  logic             pwr_down,
  output logic             pwr_ready,
  output logic             rsp_valid,
  output logic [MAX_W-1:0] rsp_data,
  output logic             rsp_invalid,
  output logic             err_timeout,
  output logic             adc_sel_n,
  output logic             adc_sck,
  output logic             adc_mosi,
  output logic             adc_read_only,
  output logic             adc_sleep,
  input  logic             adc_miso,
  input  logic             adc_idle,
  input  logic             adc_shift_done
);

  seq_state_t       st;
  logic [MAX_W-1:0] tx_sr, rx_sr, rsp_data_q;
  logic [LEN_W-1:0] cur_len, nxt_len, bit_cnt;
  logic             ro_q, inv_q, conv_pending, idle_low_seen;
  logic             sel_n_q, sck_q, mosi_q, ro_pin_q, sleep_q;
  logic             rsp_valid_q, rsp_inv_q, err_q, pwr_ready_q;
  logic             miso_s, idle_s, sdone_s;
  logic             tick, tick_en, to_clr, to_done, pu_done, idle_ok, accept;

  // Input synchronisers for the three converter status/data lines
  sadc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({adc_miso, adc_idle, adc_shift_done}),
    .q   ({miso_s, idle_s, sdone_s})
  );

  // Half-period tick for the serial clock
  assign tick_en = (st == S_SETUP) || (st == S_LOW) || (st == S_HIGH);
  sadc_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (tick_en),
    .tick (tick)
  );

  // Status wait timeout, cleared outside the two wait states
  assign to_clr = !((st == S_WAITIDLE) || (st == S_WAITSHIFT));
  sadc_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk  (clk),
    .rst  (rst),
    .clr  (to_clr),
    .done (to_done)
  );

  // Wake-up delay, held at zero while the converter sleeps
  sadc_timer #(.LIMIT(PWRUP_CYCLES)) u_pwr (
    .clk  (clk),
    .rst  (rst),
    .clr  (sleep_q),
    .done (pu_done)
  );

  assign cmd_ready = (st == S_IDLE) && pwr_ready_q && !pwr_down;
  assign accept    = cmd_valid && cmd_ready;
  // After a programming sequence a full busy pulse must be observed
  assign idle_ok   = conv_pending ? (idle_low_seen && idle_s) : idle_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      tx_sr         <= '0;
      rx_sr         <= '0;
      rsp_data_q    <= '0;
      cur_len       <= LEN_W'(DEF_LEN);
      nxt_len       <= LEN_W'(DEF_LEN);
      bit_cnt       <= '0;
      ro_q          <= 1'b0;
      inv_q         <= 1'b0;
      conv_pending  <= 1'b0;
      idle_low_seen <= 1'b0;
      sel_n_q       <= 1'b1;
      sck_q         <= 1'b0;
      mosi_q        <= 1'b0;
      ro_pin_q      <= 1'b0;
      sleep_q       <= 1'b0;
      rsp_valid_q   <= 1'b0;
      rsp_inv_q     <= 1'b0;
      err_q         <= 1'b0;
      pwr_ready_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
      pwr_ready_q <= pu_done && !sleep_q;
      if (conv_pending && !idle_s) idle_low_seen <= 1'b1;

      case (st)
        S_IDLE: begin
          if (pwr_down != sleep_q) begin
            sleep_q <= pwr_down;
          end else if (accept) begin
            tx_sr   <= cmd_word;
            ro_q    <= cmd_read_only;
            nxt_len <= cmd_len;
            rx_sr   <= '0;
            bit_cnt <= '0;
            inv_q   <= 1'b0;
            st      <= S_WAITIDLE;
          end
        end

        S_WAITIDLE: begin
          if (idle_ok || to_done) begin
            if (!idle_ok) begin
              err_q <= 1'b1;
              inv_q <= 1'b1;
            end
            conv_pending  <= 1'b0;
            idle_low_seen <= 1'b0;
            ro_pin_q      <= ro_q;
            mosi_q        <= !ro_q && tx_sr[MAX_W-1];
            tx_sr         <= {tx_sr[MAX_W-2:0], 1'b0};
            st            <= S_SETUP;
          end
        end

        S_SETUP: begin
          if (tick) begin
            sel_n_q <= 1'b0;
            st      <= S_LOW;
          end
        end

        S_LOW: begin
          if (tick) begin
            sck_q   <= 1'b1;
            rx_sr   <= {rx_sr[MAX_W-2:0], miso_s};
            bit_cnt <= bit_cnt + 1'b1;
            st      <= S_HIGH;
          end
        end

        S_HIGH: begin
          if (tick) begin
            sck_q <= 1'b0;
            if (bit_cnt == cur_len) begin
              st <= S_WAITSHIFT;
            end else begin
              mosi_q <= !ro_q && tx_sr[MAX_W-1];
              tx_sr  <= {tx_sr[MAX_W-2:0], 1'b0};
              st     <= S_LOW;
            end
          end
        end

        S_WAITSHIFT: begin
          if (sdone_s) begin
            st <= S_DONE;
          end else if (to_done) begin
            err_q <= 1'b1;
            inv_q <= 1'b1;
            st    <= S_DONE;
          end
        end

        S_DONE: begin
          sel_n_q     <= 1'b1;
          ro_pin_q    <= 1'b0;
          mosi_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= rx_sr;
          rsp_inv_q   <= inv_q;
          if (!ro_q) begin
            cur_len      <= nxt_len;
            conv_pending <= 1'b1;
          end
          st <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  assign pwr_ready     = pwr_ready_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign rsp_invalid   = rsp_inv_q;
  assign err_timeout   = err_q;
  assign adc_sel_n     = sel_n_q;
  assign adc_sck       = sck_q;
  assign adc_mosi      = mosi_q;
  assign adc_read_only = ro_pin_q;
  assign adc_sleep     = sleep_q;

  // Checker state: serial clock rising edges seen during the current select window
  logic             chk_sck_d;
  logic [LEN_W-1:0] chk_rises;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_sck_d <= 1'b0;
      chk_rises <= '0;
    end else begin
      chk_sck_d <= sck_q;
      if (sel_n_q)                 chk_rises <= '0;
      else if (sck_q && !chk_sck_d) chk_rises <= chk_rises + 1'b1;
    end
  end

  a_r3_select_with_sck_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n_q) |-> (!sck_q && !$past(sck_q)));

  a_r3_mosi_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |-> $stable(mosi_q));

  a_r4_pulse_count: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n_q) |-> (chk_rises == $past(cur_len)));

  a_r5_ro_line_hold: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_q && $past(!sel_n_q)) |-> $stable(ro_pin_q));

  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n_q) |-> (idle_s || inv_q));

  a_r2_sleep_no_select: assert property (@(posedge clk) disable iff (rst)
    sleep_q |-> sel_n_q);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |=> !rsp_valid_q);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

endmodule

// File: tb/sim_sadc_host.sv
`timescale 1ns/1ps
module sim_sadc_host;
  localparam int MAX_W = 16;
  localparam int DEF_LEN = 13;
  localparam int DIV = 5;
  localparam int PU = 40;
  localparam int TMO = 300;
  localparam int BUSY = 60;
  localparam int LEN_W = $clog2(MAX_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [MAX_W-1:0] cmd_word = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic cmd_read_only = 1'b0;
  logic pwr_down = 1'b0;
  logic pwr_ready, rsp_valid, rsp_invalid, err_timeout;
  logic [MAX_W-1:0] rsp_data;
  logic adc_sel_n, adc_sck, adc_mosi, adc_read_only, adc_sleep;
  logic adc_miso = 1'b0;
  logic adc_idle = 1'b1;
  logic adc_shift_done = 1'b1;

  always #2.5 clk = ~clk;

  sadc_host #(.MAX_W(MAX_W), .DEF_LEN(DEF_LEN), .DIV(DIV), .SYNC_STAGES(2),
              .PWRUP_CYCLES(PU), .TIMEOUT_CYCLES(TMO)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_len(cmd_len), .cmd_read_only(cmd_read_only),
    .pwr_down(pwr_down), .pwr_ready(pwr_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_invalid(rsp_invalid), .err_timeout(err_timeout),
    .adc_sel_n(adc_sel_n), .adc_sck(adc_sck), .adc_mosi(adc_mosi),
    .adc_read_only(adc_read_only), .adc_sleep(adc_sleep), .adc_miso(adc_miso),
    .adc_idle(adc_idle), .adc_shift_done(adc_shift_done));

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Device model controls, written by tasks only
  int m_len = DEF_LEN;
  logic [15:0] m_result = '0;
  bit m_stuck = 0;
  bit m_kick = 0;
  bit m_hold_shift = 0;

  // Device model state
  int cyc = 0;
  logic prev_sel = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0, prev_rsp = 1'b0;
  int m_idx = 0, m_rises = 0, busy_cnt = 0;
  logic [15:0] m_mosi_log = '0;
  logic m_ro = 1'b0;
  int sel_fall_cnt = 0, sel_fall_cyc = 0, sel_rise_cyc = 0;
  int idle_rise_cyc = 0, shift_rise_cyc = 0;
  int r3_viol = 0, ro_viol = 0, rsp_viol = 0, err_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_sel <= adc_sel_n;
    prev_sck <= adc_sck;
    prev_mosi <= adc_mosi;
    prev_rsp <= rsp_valid;
    if (err_timeout) err_cnt <= err_cnt + 1;
    if (rsp_valid && prev_rsp) rsp_viol <= rsp_viol + 1;
    if (adc_sck && prev_sck && (adc_mosi != prev_mosi)) r3_viol <= r3_viol + 1;
    if (prev_sel && !adc_sel_n) begin
      m_idx <= m_len - 1;
      adc_miso <= m_result[m_len-1];
      adc_shift_done <= 1'b0;
      m_rises <= 0;
      m_mosi_log <= '0;
      m_ro <= adc_read_only;
      sel_fall_cnt <= sel_fall_cnt + 1;
      sel_fall_cyc <= cyc;
      if (adc_sck) r3_viol <= r3_viol + 1;
    end
    if (!prev_sel && !adc_sel_n) begin
      if (adc_sck && !prev_sck) begin
        m_rises <= m_rises + 1;
        m_mosi_log <= {m_mosi_log[14:0], adc_mosi};
      end
      if (!adc_sck && prev_sck) begin
        if (m_idx > 0) begin
          m_idx <= m_idx - 1;
          adc_miso <= m_result[m_idx-1];
        end
        if (m_rises == m_len && !m_hold_shift) begin
          adc_shift_done <= 1'b1;
          shift_rise_cyc <= cyc;
        end
      end
      if (adc_read_only != m_ro) ro_viol <= ro_viol + 1;
    end
    if (!prev_sel && adc_sel_n) begin
      sel_rise_cyc <= cyc;
      if (!m_ro) begin
        adc_idle <= 1'b0;
        busy_cnt <= m_stuck ? 0 : BUSY;
      end
    end else if (m_kick) begin
      adc_idle <= 1'b1;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) begin
        adc_idle <= 1'b1;
        idle_rise_cyc <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One full command/response sequence with its own checks
  task automatic run_seq(input logic [15:0] cmd, input int len, input bit ro,
                         input logic [15:0] result, input int exp_len,
                         input bit exp_inv, input string tag);
    int n;
    int acc;
    logic [15:0] got;
    logic ginv;
    longint mask;
    longint exp_mosi;
    m_len = exp_len;
    m_result = result;
    n = 0;
    while (!cmd_ready && n < 20000) begin @(negedge clk); n++; end
    chk(cmd_ready, "R11", {tag, " ready"}, cmd_ready, 1);
    cmd_word = cmd; cmd_len = LEN_W'(len); cmd_read_only = ro; cmd_valid = 1'b1;
    acc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R11", {tag, " busy after accept"}, cmd_ready, 0);
    n = 0;
    while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
    got = rsp_data; ginv = rsp_invalid;
    @(negedge clk);
    chk(!rsp_valid, "R11", {tag, " strobe one cycle"}, rsp_valid, 0);
    mask = (longint'(1) << exp_len) - 1;
    chk(m_rises == exp_len, "R4", {tag, " sck rises"}, m_rises, exp_len);
    chk(got == (result & mask), "R6", {tag, " rsp_data"}, got, result & mask);
    chk(ginv == exp_inv, exp_inv ? "R9/R10" : "R9", {tag, " rsp_invalid"}, ginv, exp_inv);
    chk(m_ro == ro, "R5", {tag, " read-only line"}, m_ro, ro);
    exp_mosi = ro ? 0 : (cmd >> (16 - exp_len));
    chk(m_mosi_log == exp_mosi, "R5", {tag, " mosi bits"}, m_mosi_log, exp_mosi);
    if (!exp_inv)
      chk(sel_rise_cyc > shift_rise_cyc, "R8", {tag, " select after shift-done"},
          sel_rise_cyc, shift_rise_cyc);
    if (sel_fall_cyc - acc < 0)
      chk(0, "R11", {tag, " select timing"}, sel_fall_cyc, acc);
  endtask

  task automatic t_reset_powerup();
    repeat (5) @(negedge clk);
    chk(adc_sel_n == 1 && adc_sck == 0 && adc_sleep == 0 && adc_read_only == 0,
        "R1", "pins in reset", {adc_sel_n, adc_sck, adc_sleep, adc_read_only}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 0 && err_timeout == 0, "R1", "strobes after reset",
        {rsp_valid, err_timeout}, 0);
    chk(pwr_ready == 0 && cmd_ready == 0, "R1", "not ready after reset",
        {pwr_ready, cmd_ready}, 0);
    repeat (PU - 3) @(negedge clk);
    chk(pwr_ready == 0, "R2", "wake-up not yet elapsed", pwr_ready, 0);
    repeat (5) @(negedge clk);
    chk(pwr_ready == 1 && cmd_ready == 1, "R2", "ready after wake-up",
        {pwr_ready, cmd_ready}, 2'b11);
  endtask

  task automatic t_default_then_program();
    run_seq(16'hA5C3, 16, 0, 16'h1ABC, DEF_LEN, 0, "T1 default length");
    run_seq(16'h3C96, 8, 0, 16'hBEEF, 16, 0, "T2 new length");
    chk(sel_fall_cyc > idle_rise_cyc, "R7", "T2 select waits for idle rise",
        sel_fall_cyc, idle_rise_cyc);
  endtask

  task automatic t_read_only();
    run_seq(16'hFFFF, 4, 1, 16'h005A, 8, 0, "T3 read-only");
    chk(sel_fall_cyc > idle_rise_cyc, "R7", "T3 select waits for idle rise",
        sel_fall_cyc, idle_rise_cyc);
    run_seq(16'h0F0F, 3, 1, 16'h00C3, 8, 0, "T4 read-only keeps length");
    chk(err_cnt == 0, "R9", "no timeout in normal traffic", err_cnt, 0);
  endtask

  task automatic t_idle_timeout();
    int acc;
    m_stuck = 1;
    run_seq(16'h8001, 12, 0, 16'h0081, 8, 0, "T5 program then stall");
    m_stuck = 0;
    acc = cyc;
    run_seq(16'h0000, 1, 1, 16'h0ABC, 12, 1, "T6 forced start");
    chk(err_cnt == 1, "R9", "one timeout pulse", err_cnt, 1);
    chk(sel_fall_cyc - acc >= TMO, "R9", "start after full timeout",
        sel_fall_cyc - acc, TMO);
    m_kick = 1;
    repeat (4) @(negedge clk);
    m_kick = 0;
  endtask

  task automatic t_shift_timeout();
    m_hold_shift = 1;
    run_seq(16'h0000, 1, 1, 16'h0123, 12, 1, "T7 shift-done withheld");
    m_hold_shift = 0;
    chk(err_cnt == 2, "R10", "second timeout pulse", err_cnt, 2);
    chk(adc_sel_n == 1, "R10", "select released", adc_sel_n, 1);
  endtask

  task automatic t_power_down();
    int n0;
    pwr_down = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_sleep == 1, "R2", "sleep pin follows request", adc_sleep, 1);
    chk(pwr_ready == 0 && cmd_ready == 0, "R2", "not ready while asleep",
        {pwr_ready, cmd_ready}, 0);
    n0 = sel_fall_cnt;
    cmd_word = 16'hFFFF; cmd_len = LEN_W'(5); cmd_read_only = 1'b0; cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    cmd_valid = 1'b0;
    chk(sel_fall_cnt == n0, "R2", "no sequence while asleep", sel_fall_cnt, n0);
    pwr_down = 1'b0;
    repeat (PU - 3) @(negedge clk);
    chk(pwr_ready == 0 && adc_sleep == 0, "R2", "wake-up delay running",
        {pwr_ready, adc_sleep}, 0);
    repeat (8) @(negedge clk);
    chk(pwr_ready == 1, "R2", "ready after wake-up", pwr_ready, 1);
    run_seq(16'h6D2B, 10, 0, 16'h0F0F, 12, 0, "T9 after wake-up");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    t_reset_powerup();
    t_default_then_program();
    t_read_only();
    t_idle_timeout();
    t_shift_timeout();
    t_power_down();
    chk(r3_viol == 0, "R3", "select/mosi edge rules", r3_viol, 0);
    chk(ro_viol == 0, "R5", "read-only line held", ro_viol, 0);
    chk(rsp_viol == 0, "R11", "strobe width", rsp_viol, 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end
endmodule